// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block walks a single switchable power domain through its power-up and power-down handshakes. A one-cycle `on_req` or `off_req` pulse starts a sequence. The block then drives the domain's reset release, isolation, two power-switch stages, clock gate, SRAM power-down lines and bus fence in a fixed order. Between steps it waits for acknowledges from the domain: two independent power-good status lines, an SRAM power-down acknowledge vector and a bus-fence acknowledge.

Each wait samples its condition once per poll interval and is limited by a timeout. An expired wait ends the sequence, raises `err` and leaves every output where it stood. Timeouts, poll intervals and the optional fixed SRAM settle delay are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter. Parameters choose the mask widths, whether the bus fence exists, and whether power-up polls the SRAM acknowledges or waits a fixed time.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the domain is held off. `ctrl` = 5'h12, where bit 0 is active-low reset release, bit 1 is isolation, bit 2 is the first switch, bit 3 is the second switch and bit 4 is clock disable. `sram_pdn` = PDN_MASK, `bus_prot_req` = 1 (when the fence exists), and `busy`, `err`, `is_on` and `done` are all 0.
- R2: Power-up sets the first switch (ctrl 5'h16), then the second switch (5'h1E), each in its own step. It then waits for the power acknowledge.
- R3: The power acknowledge counts as "on" only when both status inputs are 1, and as "off" only when both are 0. While the two disagree, neither wait advances.
- R4: After the on acknowledge, power-up clears clock disable (5'h0E), then isolation (5'h0C), then sets reset release (5'h0D), as three separate steps.
- R5: Power-up then clears all `sram_pdn` bits and waits until every masked acknowledge bit reads 0. Only after that does it drop `bus_prot_req` and wait for `bus_prot_ack` = 0.
- R6: Power-down first raises `bus_prot_req` and waits for `bus_prot_ack` = 1. It then drives `sram_pdn` = PDN_MASK and waits until every masked acknowledge bit reads 1.
- R7: Power-down then steps through ctrl 5'h0F (isolate), 5'h0E (reset), 5'h1E (clock off), 5'h1A (first switch off) and 5'h12 (second switch off), and waits until both status inputs read 0.
- R8: A request that arrives while `busy` is 1 is ignored. The running sequence completes and no further sequence follows it.
- R9: A wait that is not satisfied within TIMEOUT_US microseconds ends the sequence. `err` goes to 1 and `busy` to 0, the outputs hold their values, and `err` stays set until the next request, which clears it.
- R10: With FORCE_WAIT=1, the SRAM step of power-up waits a fixed FWAIT_US microseconds instead of polling the acknowledges.
- R11: With BUS_PROT_EN=0, `bus_prot_req` stays 0 and both fence waits are skipped.
- R12: `done` pulses for one cycle when a sequence completes successfully. At that point `busy` falls and `is_on` takes the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Power-up request pulse (wins over off_req) |
| off_req | input | 1 | Power-down request pulse |
| pwr_ack | input | 1 | First power-good status |
| pwr_ack2 | input | 1 | Second power-good status |
| sram_ack | input | ACK_W | SRAM power-down acknowledges |
| bus_prot_ack | input | 1 | Bus fence acknowledge |
| ctrl | output | 5 | Domain control word (layout in R1) |
| sram_pdn | output | PDN_W | SRAM power-down lines |
| bus_prot_req | output | 1 | Bus fence request |
| done | output | 1 | Successful completion pulse |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last sequence timed out |
| is_on | output | 1 | Domain currently powered on |

## Verification
The bench drives a delayed model of the domain and records every change of the control word, SRAM lines and fence. A clean power-up and a clean power-down are compared against the full expected step order. Holding one status line low for a bounded time shows that a status mismatch stalls the sequence without failing it. Holding it low indefinitely separates a stall from a timeout and shows that the outputs hold until the next request. A second instance, with its SRAM acknowledges stuck high and its fence acknowledge stuck low, can only finish if the fixed wait and the fence skip are really used instead of polling.

// File: rtl/pds_pkg.sv
package pds_pkg;
   localparam int CTRL_W  = 5;
   localparam int B_RSTN  = 0;
   localparam int B_ISO   = 1;
   localparam int B_SW1   = 2;
   localparam int B_SW2   = 3;
   localparam int B_CKOFF = 4;

   typedef enum logic [4:0] {
      S_IDLE,
      S_U_SW1, S_U_SW2, S_U_PWAIT, S_U_CLK, S_U_ISO, S_U_RST,
      S_U_SRAM, S_U_SWAIT, S_U_BUS, S_U_BWAIT,
      S_D_BUS, S_D_BWAIT, S_D_SRAM, S_D_SWAIT,
      S_D_ISO, S_D_RST, S_D_CLK, S_D_SW1, S_D_SW2, S_D_PWAIT
   } seq_st_e;
endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
   parameter int LIMIT_CYC = 1000,
   parameter int POLL_CYC  = 10,
   localparam int CNT_W    = $clog2(LIMIT_CYC + 1),
   localparam int PC_W     = $clog2(POLL_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic             poll_tick,
   output logic [CNT_W-1:0] elapsed
);
   logic [PC_W-1:0] pcnt;

   assign poll_tick = run && (pcnt == PC_W'(POLL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= '0;
         pcnt    <= '0;
      end else if (!run) begin
         elapsed <= '0;
         pcnt    <= '0;
      end else begin
         if (elapsed != CNT_W'(LIMIT_CYC)) elapsed <= elapsed + 1'b1;
         pcnt <= poll_tick ? '0 : pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/pds_ack_eval.sv
module pds_ack_eval #(
   parameter int             ACK_W    = 4,
   parameter logic [ACK_W-1:0] ACK_MASK = '1
) (
   input  logic             pwr_ack,
   input  logic             pwr_ack2,
   input  logic [ACK_W-1:0] sram_ack,
   output logic             pwr_all_on,
   output logic             pwr_all_off,
   output logic             sram_all_clr,
   output logic             sram_all_set
);
   assign pwr_all_on   = pwr_ack & pwr_ack2;
   assign pwr_all_off  = ~pwr_ack & ~pwr_ack2;
   assign sram_all_clr = (sram_ack & ACK_MASK) == '0;
   assign sram_all_set = (sram_ack & ACK_MASK) == ACK_MASK;
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
   import pds_pkg::*;
#(
   parameter int               PDN_W       = 4,
   parameter int               ACK_W       = 4,
   parameter logic [PDN_W-1:0] PDN_MASK    = '1,
   parameter logic [ACK_W-1:0] ACK_MASK    = '1,
   parameter bit               BUS_PROT_EN = 1'b1,
   parameter bit               FORCE_WAIT  = 1'b0,
   parameter int               CYC_PER_US  = 100,
   parameter int               TIMEOUT_US  = 1000000,
   parameter int               POLL_US     = 10,
   parameter int               FWAIT_US    = 12000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on_req,
   input  logic              off_req,
   input  logic              pwr_ack,
   input  logic              pwr_ack2,
   input  logic [ACK_W-1:0]  sram_ack,
   input  logic              bus_prot_ack,
   output logic [CTRL_W-1:0] ctrl,
   output logic [PDN_W-1:0]  sram_pdn,
   output logic              bus_prot_req,
   output logic              done,
   output logic              busy,
   output logic              err,
   output logic              is_on
);
   localparam int  TMO_CYC   = TIMEOUT_US * CYC_PER_US;
   localparam int  POLL_CYC  = POLL_US * CYC_PER_US;
   localparam int  FW_CYC    = FWAIT_US * CYC_PER_US;
   localparam int  LIMIT_CYC = TMO_CYC;
   localparam int  CNT_W     = $clog2(LIMIT_CYC + 1);
   localparam bit  SKIP_UP_S = (ACK_MASK == '0) && !FORCE_WAIT;
   localparam bit  SKIP_DN_S = (ACK_MASK == '0);
   localparam logic [CTRL_W-1:0] CTRL_OFF = CTRL_W'(5'h12);

   initial begin
      if (CYC_PER_US < 1 || POLL_US < 1) $fatal(1, "pds: clock or poll rate must be >= 1");
      if (TIMEOUT_US < POLL_US) $fatal(1, "pds: timeout shorter than poll interval");
      if (FORCE_WAIT && FWAIT_US >= TIMEOUT_US) $fatal(1, "pds: forced wait must be below timeout");
   end

   seq_st_e          st;
   logic             run, poll_tick, tmo_hit, cond, go, sw_up_go, fail;
   logic [CNT_W-1:0] elapsed;
   logic             pwr_all_on, pwr_all_off, sram_all_clr, sram_all_set;

   pds_ack_eval #(.ACK_W(ACK_W), .ACK_MASK(ACK_MASK)) u_eval (
      .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2), .sram_ack(sram_ack),
      .pwr_all_on(pwr_all_on), .pwr_all_off(pwr_all_off),
      .sram_all_clr(sram_all_clr), .sram_all_set(sram_all_set));

   pds_wait_timer #(.LIMIT_CYC(LIMIT_CYC), .POLL_CYC(POLL_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(run),
      .poll_tick(poll_tick), .elapsed(elapsed));

   assign run = (st == S_U_PWAIT) || (st == S_U_SWAIT) || (st == S_U_BWAIT) ||
                (st == S_D_BWAIT) || (st == S_D_SWAIT) || (st == S_D_PWAIT);
   assign tmo_hit = run && (elapsed >= CNT_W'(TMO_CYC - 1));

   generate
      if (FORCE_WAIT) begin : g_fixed_wait
         assign sw_up_go = elapsed >= CNT_W'(FW_CYC - 1);
      end else begin : g_poll_wait
         assign sw_up_go = poll_tick && sram_all_clr;
      end
   endgenerate

   always_comb begin
      case (st)
         S_U_PWAIT: cond = pwr_all_on;
         S_U_BWAIT: cond = !bus_prot_ack;
         S_D_BWAIT: cond = bus_prot_ack;
         S_D_SWAIT: cond = sram_all_set;
         S_D_PWAIT: cond = pwr_all_off;
         default:   cond = 1'b0;
      endcase
   end

   assign go   = (st == S_U_SWAIT) ? sw_up_go : (poll_tick && cond);
   assign fail = tmo_hit && !go;
   assign busy = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= S_IDLE;
         ctrl         <= CTRL_OFF;
         sram_pdn     <= PDN_MASK;
         bus_prot_req <= BUS_PROT_EN;
         done         <= 1'b0;
         err          <= 1'b0;
         is_on        <= 1'b0;
      end else begin
         done <= 1'b0;
         if (run && fail) begin
            err <= 1'b1;
            st  <= S_IDLE;
         end else begin
            case (st)
               S_IDLE: begin
                  if (on_req) begin
                     err <= 1'b0;
                     st  <= S_U_SW1;
                  end else if (off_req) begin
                     err <= 1'b0;
                     st  <= BUS_PROT_EN ? S_D_BUS : S_D_SRAM;
                  end
               end
               S_U_SW1:   begin ctrl[B_SW1]   <= 1'b1; st <= S_U_SW2; end
               S_U_SW2:   begin ctrl[B_SW2]   <= 1'b1; st <= S_U_PWAIT; end
               S_U_PWAIT: if (go) st <= S_U_CLK;
               S_U_CLK:   begin ctrl[B_CKOFF] <= 1'b0; st <= S_U_ISO; end
               S_U_ISO:   begin ctrl[B_ISO]   <= 1'b0; st <= S_U_RST; end
               S_U_RST:   begin ctrl[B_RSTN]  <= 1'b1; st <= S_U_SRAM; end
               S_U_SRAM: begin
                  sram_pdn <= '0;
                  st       <= SKIP_UP_S ? S_U_BUS : S_U_SWAIT;
               end
               S_U_SWAIT: if (go) st <= S_U_BUS;
               S_U_BUS: begin
                  if (BUS_PROT_EN) begin
                     bus_prot_req <= 1'b0;
                     st           <= S_U_BWAIT;
                  end else begin
                     done  <= 1'b1;
                     is_on <= 1'b1;
                     st    <= S_IDLE;
                  end
               end
               S_U_BWAIT: if (go) begin
                  done  <= 1'b1;
                  is_on <= 1'b1;
                  st    <= S_IDLE;
               end
               S_D_BUS:   begin bus_prot_req <= 1'b1; st <= S_D_BWAIT; end
               S_D_BWAIT: if (go) st <= S_D_SRAM;
               S_D_SRAM: begin
                  sram_pdn <= PDN_MASK;
                  st       <= SKIP_DN_S ? S_D_ISO : S_D_SWAIT;
               end
               S_D_SWAIT: if (go) st <= S_D_ISO;
               S_D_ISO:   begin ctrl[B_ISO]   <= 1'b1; st <= S_D_RST; end
               S_D_RST:   begin ctrl[B_RSTN]  <= 1'b0; st <= S_D_CLK; end
               S_D_CLK:   begin ctrl[B_CKOFF] <= 1'b1; st <= S_D_SW1; end
               S_D_SW1:   begin ctrl[B_SW1]   <= 1'b0; st <= S_D_SW2; end
               S_D_SW2:   begin ctrl[B_SW2]   <= 1'b0; st <= S_D_PWAIT; end
               S_D_PWAIT: if (go) begin
                  done  <= 1'b1;
                  is_on <= 1'b0;
                  st    <= S_IDLE;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
   parameter int PDN_W       = 4,
   parameter bit BUS_PROT_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             on_req,
   input logic             off_req,
   input logic [4:0]       ctrl,
   input logic [PDN_W-1:0] sram_pdn,
   input logic             bus_prot_req,
   input logic             done,
   input logic             busy,
   input logic             err,
   input logic             is_on
);
   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !err));
   // R12
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R9
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);
   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !on_req && !off_req) |=> err);
   // R4
   iso_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[1] |-> (ctrl[2] && ctrl[3]));
   // R4
   on_state_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_on && !busy && !err) |-> (ctrl == 5'h0D));
   // R1
   off_state_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_on && !busy && !err) |-> (ctrl == 5'h12));
   // R5
   fence_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BUS_PROT_EN && !bus_prot_req) |-> (ctrl == 5'h0D && sram_pdn == '0));
   // R11
   fence_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !BUS_PROT_EN |-> !bus_prot_req);
endmodule

bind pwr_domain_seq pds_chk #(.PDN_W(PDN_W), .BUS_PROT_EN(BUS_PROT_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
   .ctrl(ctrl), .sram_pdn(sram_pdn), .bus_prot_req(bus_prot_req),
   .done(done), .busy(busy), .err(err), .is_on(is_on));

// File: tb/pwr_domain_seq_tb.sv
`timescale 1ns/1ps
module pwr_domain_seq_tb;
   localparam int TMO = 40;
   localparam int FW  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_run = 0, n_fail = 0;

   // main instance
   logic       on_req = 0, off_req = 0;
   logic       pwr_ack, pwr_ack2, bus_prot_ack;
   logic [3:0] sram_ack;
   logic [4:0] ctrl;
   logic [3:0] sram_pdn;
   logic       bus_prot_req, done, busy, err, is_on;
   logic       hold2 = 0;

   pwr_domain_seq #(.CYC_PER_US(1), .TIMEOUT_US(TMO), .POLL_US(2), .FWAIT_US(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
      .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2), .sram_ack(sram_ack),
      .bus_prot_ack(bus_prot_ack), .ctrl(ctrl), .sram_pdn(sram_pdn),
      .bus_prot_req(bus_prot_req), .done(done), .busy(busy), .err(err), .is_on(is_on));

   // fixed-wait instance without bus fence
   logic       f_on = 0, f_off = 0, f_ack, f_ack2;
   logic [4:0] f_ctrl;
   logic [3:0] f_pdn;
   logic       f_bp, f_done, f_busy, f_err, f_is_on;

   pwr_domain_seq #(.CYC_PER_US(1), .TIMEOUT_US(TMO), .POLL_US(2), .FWAIT_US(FW),
                    .FORCE_WAIT(1'b1), .BUS_PROT_EN(1'b0)) u_fw (
      .clk(clk), .rst_n(rst_n), .on_req(f_on), .off_req(f_off),
      .pwr_ack(f_ack), .pwr_ack2(f_ack2), .sram_ack(4'hF),
      .bus_prot_ack(1'b0), .ctrl(f_ctrl), .sram_pdn(f_pdn),
      .bus_prot_req(f_bp), .done(f_done), .busy(f_busy), .err(f_err), .is_on(f_is_on));

   // domain model: acknowledges follow the controls after three cycles
   logic [2:0] s1_d = 0, s2_d = 0, bp_d = 0, fs1_d = 0, fs2_d = 0;
   logic [3:0] pd0 = 0, pd1 = 0, pd2 = 0;
   always @(negedge clk) begin
      s1_d  <= {s1_d[1:0], ctrl[2]};
      s2_d  <= {s2_d[1:0], ctrl[3]};
      bp_d  <= {bp_d[1:0], bus_prot_req};
      pd0 <= sram_pdn; pd1 <= pd0; pd2 <= pd1;
      fs1_d <= {fs1_d[1:0], f_ctrl[2]};
      fs2_d <= {fs2_d[1:0], f_ctrl[3]};
   end
   assign pwr_ack      = s1_d[2];
   assign pwr_ack2     = s2_d[2] & ~hold2;
   assign bus_prot_ack = bp_d[2];
   assign sram_ack     = pd2;
   assign f_ack        = fs1_d[2];
   assign f_ack2       = fs2_d[2];

   // change recorder: {bus_prot_req, sram_pdn, ctrl}
   logic [9:0] seq [$];
   logic [9:0] last_v;
   always @(negedge clk) begin
      if (rst_n && {bus_prot_req, sram_pdn, ctrl} != last_v) begin
         seq.push_back({bus_prot_req, sram_pdn, ctrl});
         last_v = {bus_prot_req, sram_pdn, ctrl};
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic r);
      @(negedge clk); r = 1'b1;
      @(negedge clk); r = 1'b0;
   endtask

   task automatic wait_end(output int cyc);
      cyc = 1;
      while (!(done || err) && cyc < 500) begin
         @(negedge clk); cyc++;
      end
   endtask

   task automatic cmp_seq(input logic [9:0] exp [], input string req);
      chk(seq.size() == exp.size(), req, seq.size(), exp.size());
      for (int i = 0; i < exp.size() && i < seq.size(); i++)
         chk(seq[i] == exp[i], req, seq[i], exp[i]);
   endtask

   task automatic t_reset();
      // R1
      chk(ctrl == 5'h12, "R1 ctrl", ctrl, 5'h12);
      chk(sram_pdn == 4'hF && bus_prot_req, "R1 pdn/fence", {bus_prot_req, sram_pdn}, 5'h1F);
      chk({busy, err, is_on, done} == 4'b0, "R1 status", {busy, err, is_on, done}, 0);
   endtask

   task automatic t_up();
      int c;
      logic [9:0] e [] = '{{1'b1,4'hF,5'h16}, {1'b1,4'hF,5'h1E}, {1'b1,4'hF,5'h0E},
                           {1'b1,4'hF,5'h0C}, {1'b1,4'hF,5'h0D}, {1'b1,4'h0,5'h0D},
                           {1'b0,4'h0,5'h0D}};
      seq.delete();
      pulse(on_req);
      wait_end(c);
      chk(done && !err, "R12 up done", {done, err}, 2'b10);
      @(negedge clk);
      chk(is_on && !busy, "R12 up is_on", {is_on, busy}, 2'b10);
      // R2 R4 R5: order of switch, clock, isolation, reset, SRAM, fence
      cmp_seq(e, "R2 R4 R5 up order");
   endtask

   task automatic t_down_ignore();
      int c;
      logic [9:0] e [] = '{{1'b1,4'h0,5'h0D}, {1'b1,4'hF,5'h0D}, {1'b1,4'hF,5'h0F},
                           {1'b1,4'hF,5'h0E}, {1'b1,4'hF,5'h1E}, {1'b1,4'hF,5'h1A},
                           {1'b1,4'hF,5'h12}};
      seq.delete();
      pulse(off_req);
      repeat (4) @(negedge clk);
      pulse(on_req);   // R8: arrives while busy
      wait_end(c);
      chk(done && !err, "R12 down done", {done, err}, 2'b10);
      // R6 R7
      cmp_seq(e, "R6 R7 down order");
      repeat (30) @(negedge clk);
      chk(!is_on && !busy && ctrl == 5'h12, "R8 busy request ignored",
          {is_on, busy, ctrl}, 7'h12);
   endtask

   task automatic t_mismatch();
      int c;
      hold2 = 1'b1;
      pulse(on_req);
      repeat (22) @(negedge clk);
      // R3: first status on, second off -> no progress
      chk(busy && ctrl == 5'h1E && !err, "R3 mismatch stalls", {busy, err, ctrl}, 7'h5E);
      hold2 = 1'b0;
      wait_end(c);
      chk(done && !err, "R3 completes after agreement", {done, err}, 2'b10);
      pulse(off_req);
      wait_end(c);
      chk(done && !is_on, "R3 off again", {done, is_on}, 2'b10);
   endtask

   task automatic t_timeout();
      int c;
      hold2 = 1'b1;
      pulse(on_req);
      wait_end(c);
      chk(err && !busy, "R9 error raised", {err, busy}, 2'b10);
      chk(c >= TMO, "R9 timeout length", c, TMO);
      repeat (10) @(negedge clk);
      chk(err && ctrl == 5'h1E && !is_on, "R9 outputs held", {err, is_on, ctrl}, 7'h5E);
      hold2 = 1'b0;
      @(negedge clk); on_req = 1'b1;
      @(negedge clk); on_req = 1'b0;
      chk(!err && busy, "R9 cleared by request", {err, busy}, 2'b01);
      wait_end(c);
      chk(done && !err, "R9 retry completes", {done, err}, 2'b10);
   endtask

   task automatic t_fixed();
      int c;
      pulse(f_on);
      c = 0;
      while (f_pdn != 4'h0 && c < 200) begin @(negedge clk); c++; end
      c = 0;
      while (!f_done && !f_err && c < 200) begin @(negedge clk); c++; end
      // R10: SRAM acks stuck high, so only the fixed wait can finish
      chk(f_done && !f_err, "R10 fixed wait done", {f_done, f_err}, 2'b10);
      chk(c >= FW && c <= FW + 2, "R10 fixed wait length", c, FW + 1);
      // R11: fence ack stuck low, power-down must still finish
      pulse(f_off);
      c = 0;
      while (!f_done && !f_err && c < 200) begin @(negedge clk); c++; end
      chk(f_done && !f_err && !f_bp, "R11 fence skipped", {f_done, f_err, f_bp}, 3'b100);
      @(negedge clk);
      chk(!f_is_on && f_ctrl == 5'h12, "R11 off reached", {f_is_on, f_ctrl}, 6'h12);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_up();
      t_down_ignore();
      t_mismatch();
      t_timeout();
      t_fixed();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule